// File: doc/BRIEF.md
# Two-Way Sub-Blocked Instruction Cache

This block is a read-only instruction cache between a processor fetch port and an external memory port. It has two ways and 128 sets. Each set holds one 16-byte block per way, split into four 32-bit sub-blocks. Every way entry keeps four things:
- an address tag,
- a block-level valid flag,
- one valid flag for each sub-block,
- a lock flag.

Each set also keeps one replacement bit that names its least recently used way.

A fetch that finds its word returns it in the same cycle. A fetch that misses starts a single-word external read. When the memory answers, the word goes to the processor and into the cache in the same cycle. If a matching tag is already present, only the missing sub-block is filled. Otherwise a victim way is chosen and reallocated. A lock flag keeps its way from being evicted. Locking is controlled by a level input: while it is high, new allocations are made locked. A one-cycle invalidate pulse clears every block's valid and lock flags by sweeping through the sets.

The controller is built around three states:
- `ST_IDLE` serves hits. It moves to `ST_FILL` on a miss and to `ST_SWEEP` when an invalidate is pending.
- `ST_FILL` drives the external request. It returns to `ST_IDLE` in the cycle the memory answers.
- `ST_SWEEP` clears one set per cycle. It returns to `ST_IDLE` after the last set.

Top module: `icache2w_top`

## Requirements
- R1: Addresses on both ports are 30-bit word addresses. Bits 1:0 select the sub-block, bits 8:2 select the set, and bits 29:9 are the tag. Words with the same set bits but different tags compete for the same two ways.
- R2: A fetch whose word is cached raises `fetch_ready` and `fetch_hit` in the request cycle, with the cached word on `fetch_rdata`.
- R3: On a miss, `fetch_ready` stays low in the request cycle. From the next cycle `mem_req` is high and `mem_waddr` equals the requested word address. Both are held unchanged until `mem_rvalid`.
- R4: In the cycle `mem_rvalid` is high during a fill, `fetch_ready` is 1, `fetch_hit` is 0 and `fetch_rdata` equals `mem_rdata`. The word is written into the cache, so a later fetch of it hits.
- R5: A word hits only if its way has the block valid flag set, a matching tag, and its own sub-block valid flag set. A miss in a way whose tag matches fills only that sub-block and leaves its other sub-blocks valid.
- R6: A miss whose tag matches neither way reallocates the victim way. It writes the new tag, sets the block valid flag, and leaves only the filled sub-block valid.
- R7: Each set has one replacement bit. It is 0 after reset and is set to point at the way not used by each hit or fill. The victim is the way it points at.
- R8: An allocation made while `fill_lock` is 1 locks that entry. A locked least-recently-used way is passed over for an unlocked other way. If both ways are locked, the word is returned but not stored, and both resident blocks keep hitting.
- R9: A one-cycle `inval_all` pulse clears the block valid and lock flags of every entry. A fetch issued in the cycle after the pulse gets its external request after exactly 129 cycles. No fetch hits before that.
- R10: After an invalidate, sub-block valid flags left set from before do not produce a hit. Reallocating the block clears them.
- R11: After reset, `mem_req`, `fetch_ready` and `fetch_hit` are 0, and the first fetch of any address misses.
- R12: `fetch_ready` and `fetch_hit` are never high while `fetch_req` is low. `fetch_hit` is never high without `fetch_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_waddr | input | 30 | Requested word address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_hit | output | 1 | Completing fetch was served from the cache |
| fetch_rdata | output | 32 | Instruction word |
| mem_req | output | 1 | External single-word read request |
| mem_waddr | output | 30 | External read word address |
| mem_rvalid | input | 1 | External read data valid |
| mem_rdata | input | 32 | External read data |
| inval_all | input | 1 | Invalidate all entries (pulse) |
| fill_lock | input | 1 | Lock the entry allocated by a fill |

## Verification
Results fall due at three distances from a stimulus:
- A hit completes in the request cycle.
- A miss raises `mem_req` one cycle after the request. It completes in the same cycle as the memory's `mem_rvalid`, which the bench gives after two request cycles.
- A fetch issued right after an invalidate pulse waits exactly 129 cycles before its external request.

The bench drives every input on the falling edge and samples one nanosecond later. In each cycle of a fetch it counts the cycles since the request and compares the outputs with a behavioural model of the tags, valid flags, locks and replacement bits. A result arriving one cycle early or late is therefore reported as a failure.

// File: rtl/icache2w_pkg.sv
package icache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_SWEEP
    } ic_state_e;
endpackage

// File: rtl/icache2w_tags.sv
module icache2w_tags #(
    parameter int TAG_W = 21,
    parameter int SET_W = 7,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    input  logic [SUB_W-1:0] lk_sub,
    output logic [1:0]       way_hit,
    output logic [1:0]       way_match,
    output logic [1:0]       way_lock,
    output logic             set_lru,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic             fill_alloc,
    input  logic             fill_lock,
    input  logic             lru_en,
    input  logic             lru_way,
    input  logic             clr_en,
    input  logic [SET_W-1:0] clr_set
);
    localparam int SETS = 1 << SET_W;
    localparam int SUBS = 1 << SUB_W;

    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SUBS-1:0]  sbv_q [SETS];
        logic [SETS-1:0]  tv_q;
        logic [SETS-1:0]  lk_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tv_q <= '0;
                lk_q <= '0;
                for (int i = 0; i < SETS; i++) begin
                    tag_q[i] <= '0;
                    sbv_q[i] <= '0;
                end
            end else if (clr_en) begin
                tv_q[clr_set] <= 1'b0;
                lk_q[clr_set] <= 1'b0;
            end else if (fill_en && (fill_way == 1'(w))) begin
                if (fill_alloc) begin
                    tag_q[lk_set] <= lk_tag;
                    tv_q[lk_set]  <= 1'b1;
                    lk_q[lk_set]  <= fill_lock;
                    sbv_q[lk_set] <= SUBS'(1) << lk_sub;
                end else begin
                    sbv_q[lk_set][lk_sub] <= 1'b1;
                end
            end
        end

        assign way_match[w] = tv_q[lk_set] && (tag_q[lk_set] == lk_tag);
        assign way_hit[w]   = way_match[w] && sbv_q[lk_set][lk_sub];
        assign way_lock[w]  = lk_q[lk_set];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (lru_en) begin
            lru_q[lk_set] <= ~lru_way;
        end
    end

    assign set_lru = lru_q[lk_set];
endmodule

// File: rtl/icache2w_data.sv
module icache2w_data #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 9
) (
    input  logic                 clk,
    input  logic [IDX_W-1:0]     idx,
    output logic [1:0][DATA_W-1:0] rd_word,
    input  logic                 we,
    input  logic                 wr_way,
    input  logic [DATA_W-1:0]    wdata
);
    localparam int DEPTH = 1 << IDX_W;

    for (genvar w = 0; w < 2; w++) begin : g_bank
        logic [DATA_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wr_way == 1'(w))) begin
                mem_q[idx] <= wdata;
            end
        end

        assign rd_word[w] = mem_q[idx];
    end
endmodule

// File: rtl/icache2w_ctrl.sv
module icache2w_ctrl
    import icache2w_pkg::*;
#(
    parameter int SET_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_req,
    input  logic [1:0]       way_hit,
    input  logic [1:0]       way_match,
    input  logic [1:0]       way_lock,
    input  logic             set_lru,
    input  logic             mem_rvalid,
    input  logic             inval_all,
    output ic_state_e        state,
    output logic             fetch_ready,
    output logic             fetch_hit,
    output logic             fwd_sel,
    output logic             capture,
    output logic             mem_req,
    output logic             lru_en,
    output logic             lru_way,
    output logic             fill_en,
    output logic             fill_way,
    output logic             fill_alloc,
    output logic             clr_en,
    output logic [SET_W-1:0] clr_set
);
    ic_state_e        state_q, state_d;
    logic [SET_W-1:0] sweep_q;
    logic             pend_q;
    logic             victim;
    logic             victim_ok;

    // State register, sweep index and pending invalidate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sweep_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sweep_q <= (state_q == ST_SWEEP) ? sweep_q + 1'b1 : '0;
            pend_q  <= inval_all | (pend_q & (state_q != ST_IDLE));
        end
    end

    // Victim choice: LRU way unless it is locked and the other is free
    always_comb begin
        victim = set_lru;
        if (way_lock[victim] && !way_lock[~victim]) begin
            victim = ~victim;
        end
        victim_ok = !way_lock[victim];
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        fetch_ready = 1'b0;
        fetch_hit   = 1'b0;
        fwd_sel     = 1'b0;
        capture     = 1'b0;
        mem_req     = 1'b0;
        lru_en      = 1'b0;
        lru_way     = 1'b0;
        fill_en     = 1'b0;
        fill_way    = 1'b0;
        fill_alloc  = 1'b0;
        clr_en      = 1'b0;
        clr_set     = sweep_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_q) begin
                    state_d = ST_SWEEP;
                end else if (fetch_req) begin
                    if (|way_hit) begin
                        fetch_ready = 1'b1;
                        fetch_hit   = 1'b1;
                        lru_en      = 1'b1;
                        lru_way     = way_hit[1];
                    end else begin
                        capture = 1'b1;
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_rvalid) begin
                    fetch_ready = 1'b1;
                    fwd_sel     = 1'b1;
                    state_d     = ST_IDLE;
                    if (|way_match) begin
                        fill_en  = 1'b1;
                        fill_way = way_match[1];
                        lru_en   = 1'b1;
                        lru_way  = way_match[1];
                    end else if (victim_ok) begin
                        fill_en    = 1'b1;
                        fill_way   = victim;
                        fill_alloc = 1'b1;
                        lru_en     = 1'b1;
                        lru_way    = victim;
                    end
                end
            end
            ST_SWEEP: begin
                clr_en = 1'b1;
                if (&sweep_q) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/icache2w_top.sv
module icache2w_top
    import icache2w_pkg::*;
#(
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int SET_W   = 7,
    parameter int SUB_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    input  logic [WADDR_W-1:0] fetch_waddr,
    output logic               fetch_ready,
    output logic               fetch_hit,
    output logic [DATA_W-1:0]  fetch_rdata,
    output logic               mem_req,
    output logic [WADDR_W-1:0] mem_waddr,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               inval_all,
    input  logic               fill_lock
);
    localparam int TAG_W = WADDR_W - SET_W - SUB_W;
    localparam int IDX_W = SET_W + SUB_W;

    ic_state_e               state;
    logic [WADDR_W-1:0]      addr_q;
    logic [WADDR_W-1:0]      lk_addr;
    logic [1:0]              way_hit, way_match, way_lock;
    logic                    set_lru;
    logic                    fwd_sel, capture;
    logic                    lru_en, lru_way;
    logic                    fill_en, fill_way, fill_alloc;
    logic                    clr_en;
    logic [SET_W-1:0]        clr_set;
    logic [1:0][DATA_W-1:0]  rd_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= fetch_waddr;
        end
    end

    assign lk_addr   = (state == ST_FILL) ? addr_q : fetch_waddr;
    assign mem_waddr = addr_q;

    icache2w_tags #(.TAG_W(TAG_W), .SET_W(SET_W), .SUB_W(SUB_W)) tags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (lk_addr[SUB_W +: SET_W]),
        .lk_tag     (lk_addr[WADDR_W-1 -: TAG_W]),
        .lk_sub     (lk_addr[SUB_W-1:0]),
        .way_hit    (way_hit),
        .way_match  (way_match),
        .way_lock   (way_lock),
        .set_lru    (set_lru),
        .fill_en    (fill_en),
        .fill_way   (fill_way),
        .fill_alloc (fill_alloc),
        .fill_lock  (fill_lock),
        .lru_en     (lru_en),
        .lru_way    (lru_way),
        .clr_en     (clr_en),
        .clr_set    (clr_set)
    );

    icache2w_data #(.DATA_W(DATA_W), .IDX_W(IDX_W)) data_i (
        .clk     (clk),
        .idx     (lk_addr[IDX_W-1:0]),
        .rd_word (rd_word),
        .we      (fill_en),
        .wr_way  (fill_way),
        .wdata   (mem_rdata)
    );

    icache2w_ctrl #(.SET_W(SET_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .way_hit     (way_hit),
        .way_match   (way_match),
        .way_lock    (way_lock),
        .set_lru     (set_lru),
        .mem_rvalid  (mem_rvalid),
        .inval_all   (inval_all),
        .state       (state),
        .fetch_ready (fetch_ready),
        .fetch_hit   (fetch_hit),
        .fwd_sel     (fwd_sel),
        .capture     (capture),
        .mem_req     (mem_req),
        .lru_en      (lru_en),
        .lru_way     (lru_way),
        .fill_en     (fill_en),
        .fill_way    (fill_way),
        .fill_alloc  (fill_alloc),
        .clr_en      (clr_en),
        .clr_set     (clr_set)
    );

    assign fetch_rdata = fwd_sel ? mem_rdata : rd_word[way_hit[1]];
endmodule

// File: rtl/icache2w_chk.sv
module icache2w_chk #(
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fetch_req,
    input logic               fetch_ready,
    input logic               fetch_hit,
    input logic [DATA_W-1:0]  fetch_rdata,
    input logic               mem_req,
    input logic [WADDR_W-1:0] mem_waddr,
    input logic               mem_rvalid,
    input logic [DATA_W-1:0]  mem_rdata,
    input logic               inval_all,
    input logic [1:0]         way_hit
);
    AST_READY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready || fetch_hit) |-> fetch_req); // R12

    AST_HIT_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> fetch_ready); // R12

    AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit)); // R5

    AST_MISS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |-> (fetch_ready && !fetch_hit && fetch_rdata == mem_rdata)); // R4

    AST_MEMADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_waddr))); // R3

    AST_NO_HIT_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fetch_hit); // R2

    AST_NO_HIT_AFTER_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> !fetch_hit); // R9
endmodule

bind icache2w_top icache2w_chk #(.WADDR_W(WADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .fetch_ready (fetch_ready),
    .fetch_hit   (fetch_hit),
    .fetch_rdata (fetch_rdata),
    .mem_req     (mem_req),
    .mem_waddr   (mem_waddr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .inval_all   (inval_all),
    .way_hit     (way_hit)
);

// File: tb/icache2w_tb_top.sv
`timescale 1ns/1ps
module icache2w_tb_top;
    localparam int WA    = 30;
    localparam int DW    = 32;
    localparam int SETS  = 128;
    localparam int LAT   = 2;
    localparam int LIMIT = SETS + 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0;
    logic [WA-1:0] fetch_waddr = '0;
    logic          fetch_ready, fetch_hit;
    logic [DW-1:0] fetch_rdata;
    logic          mem_req;
    logic [WA-1:0] mem_waddr;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          inval_all = 1'b0;
    logic          fill_lock = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    icache2w_top dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_waddr(fetch_waddr),
        .fetch_ready(fetch_ready), .fetch_hit(fetch_hit), .fetch_rdata(fetch_rdata),
        .mem_req(mem_req), .mem_waddr(mem_waddr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .inval_all(inval_all), .fill_lock(fill_lock)
    );

    // Behavioural model of cache state
    bit        m_tv  [2][SETS];
    bit        m_lk  [2][SETS];
    bit [20:0] m_tag [2][SETS];
    bit        m_sbv [2][SETS][4];
    bit        m_lru [SETS];

    function automatic logic [DW-1:0] memf(input logic [WA-1:0] a);
        return ({2'b00, a} * 32'h9E37_79B1) ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [WA-1:0] mk(input int t, input int s, input int b);
        return {21'(t), 7'(s), 2'(b)};
    endfunction

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
        end
    endtask

    task automatic mlook(input logic [WA-1:0] a, output bit h, output int hw,
                         output bit m, output int mw);
        int s = int'(a[8:2]);
        int b = int'(a[1:0]);
        h = 0; hw = 0; m = 0; mw = 0;
        for (int w = 0; w < 2; w++) begin
            if (m_tv[w][s] && m_tag[w][s] == a[29:9]) begin
                m = 1; mw = w;
                if (m_sbv[w][s][b]) begin h = 1; hw = w; end
            end
        end
    endtask

    task automatic mupdate(input logic [WA-1:0] a, input bit h, input int hw,
                           input bit m, input int mw, input bit lk);
        int s = int'(a[8:2]);
        int b = int'(a[1:0]);
        int v;
        if (h) begin
            m_lru[s] = (hw == 0);
        end else if (m) begin
            m_sbv[mw][s][b] = 1;
            m_lru[s] = (mw == 0);
        end else begin
            v = int'(m_lru[s]);
            if (m_lk[v][s] && !m_lk[1-v][s]) v = 1 - v;
            if (!m_lk[v][s]) begin
                m_tag[v][s] = a[29:9];
                m_tv[v][s]  = 1;
                m_lk[v][s]  = lk;
                for (int k = 0; k < 4; k++) m_sbv[v][s][k] = (k == b);
                m_lru[s] = (v == 0);
            end
        end
    endtask

    task automatic do_fetch(input logic [WA-1:0] a, input int pre_exp, input string lbl);
        bit eh, em;
        int ew, emw, cyc, pre, mc;
        bit done;
        mlook(a, eh, ew, em, emw);
        cyc = 0; pre = 0; mc = 0; done = 0;
        @(negedge clk);
        fetch_req   = 1'b1;
        fetch_waddr = a;
        while (!done) begin
            mem_rvalid = (mc == LAT);
            mem_rdata  = (mc == LAT) ? memf(a) : '0;
            #1;
            if (fetch_ready) begin
                if (eh) begin
                    chk(cyc == 0 && fetch_hit, {"R2 hit in request cycle ", lbl}, cyc, 0);
                end else begin
                    chk(!fetch_hit && mem_rvalid, {"R4 miss completes with memory data ", lbl},
                        fetch_hit, 0);
                    chk(pre == pre_exp, {"R3 R9 cycles before external fetch ", lbl}, pre, pre_exp);
                end
                chk(fetch_rdata == memf(a), {"R4 R2 returned word ", lbl}, fetch_rdata, memf(a));
                done = 1;
            end else begin
                chk(!fetch_hit, {"R12 hit without ready ", lbl}, fetch_hit, 0);
                if (eh && cyc == 0) chk(0, {"R2 R5 expected hit ", lbl}, 0, 1);
                if (mem_req) begin
                    chk(mem_waddr == a, {"R3 external address ", lbl}, mem_waddr, a);
                    mc++;
                end else begin
                    if (mc > 0) chk(0, {"R3 request dropped ", lbl}, 0, 1);
                    pre++;
                end
                cyc++;
                if (cyc > LIMIT) begin
                    chk(0, {"R3 fetch never completed ", lbl}, cyc, LIMIT);
                    done = 1;
                end
            end
            if (!done) @(negedge clk);
        end
        mupdate(a, eh, ew, em, emw, fill_lock);
        @(negedge clk);
        fetch_req  = 1'b0;
        mem_rvalid = 1'b0;
        #1;
        chk(!fetch_ready && !fetch_hit && !mem_req, {"R12 quiet without request ", lbl},
            {fetch_ready, fetch_hit, mem_req}, 0);
    endtask

    task automatic pulse_inval();
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < 2; w++) begin
                m_tv[w][s] = 0;
                m_lk[w][s] = 0;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        chk(0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        #1;
        chk(!fetch_ready && !fetch_hit && !mem_req, "R11 outputs in reset",
            {fetch_ready, fetch_hit, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!fetch_ready && !mem_req, "R11 idle after reset", {fetch_ready, mem_req}, 0);

        // First fills, hits and partial fills in set 5
        do_fetch(mk(1, 5, 0), 1, "R11 first fetch misses");
        do_fetch(mk(1, 5, 0), 1, "R2 repeat hits");
        do_fetch(mk(1, 6, 0), 1, "R1 other set misses");
        do_fetch(mk(1, 5, 1), 1, "R5 partial fill");
        do_fetch(mk(1, 5, 0), 1, "R5 old sub-block kept");
        do_fetch(mk(1, 5, 1), 1, "R5 new sub-block hits");
        do_fetch(mk(2, 5, 0), 1, "R1 R7 second tag to other way");
        do_fetch(mk(1, 5, 0), 1, "R7 both resident");
        do_fetch(mk(2, 5, 0), 1, "R7 both resident b");
        do_fetch(mk(3, 5, 2), 1, "R6 R7 third tag evicts LRU");
        do_fetch(mk(2, 5, 0), 1, "R7 survivor hits");
        do_fetch(mk(1, 5, 0), 1, "R7 evicted misses");
        do_fetch(mk(3, 5, 0), 1, "R6 only filled sub-block valid");

        // Both ways locked in set 9
        fill_lock = 1'b1;
        do_fetch(mk(1, 9, 0), 1, "R8 locked fill a");
        do_fetch(mk(2, 9, 0), 1, "R8 locked fill b");
        fill_lock = 1'b0;
        do_fetch(mk(3, 9, 0), 1, "R8 both locked no allocate");
        do_fetch(mk(3, 9, 0), 1, "R8 still misses");
        do_fetch(mk(1, 9, 0), 1, "R8 locked a kept");
        do_fetch(mk(2, 9, 0), 1, "R8 locked b kept");

        // One locked way in set 12
        fill_lock = 1'b1;
        do_fetch(mk(1, 12, 0), 1, "R8 lock way0");
        fill_lock = 1'b0;
        do_fetch(mk(2, 12, 0), 1, "R8 unlocked way1");
        do_fetch(mk(1, 12, 0), 1, "R8 hit locked");
        do_fetch(mk(2, 12, 0), 1, "R8 hit unlocked");
        do_fetch(mk(3, 12, 0), 1, "R8 skip locked LRU");
        do_fetch(mk(1, 12, 0), 1, "R8 locked survives");
        do_fetch(mk(2, 12, 0), 1, "R8 unlocked evicted");

        // Invalidate with stale sub-block flags in set 20
        for (int b = 0; b < 4; b++) do_fetch(mk(4, 20, b), 1, "R5 fill block");
        pulse_inval();
        do_fetch(mk(4, 20, 0), SETS + 1, "R9 sweep delay and miss");
        do_fetch(mk(4, 20, 1), 1, "R10 stale sub-block flag ignored");
        do_fetch(mk(2, 5, 0), 1, "R9 all entries cleared");
        do_fetch(mk(3, 9, 0), 1, "R9 locks cleared");
        do_fetch(mk(4, 9, 0), 1, "R9 set usable after unlock");

        // Pseudo-random mix of tags, sets and lock
        lf = 32'h1ACE_B00C;
        for (int n = 0; n < 300; n++) begin
            int sets_pick [4] = '{0, 1, 127, 5};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            fill_lock = (lf[10:8] == 3'd0);
            do_fetch(mk(int'(lf[1:0]), sets_pick[lf[3:2]], int'(lf[5:4])), 1, "R1 R7 mixed");
            if (n == 150) begin
                fill_lock = 1'b0;
                pulse_inval();
                do_fetch(mk(1, 1, 1), SETS + 1, "R9 second sweep");
            end
        end
        fill_lock = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule